// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a 32-bit physical address by reading a two-level translation structure kept in physical memory. A root register holds the physical address of the top-level directory; software may reload it at any time, for example when switching between processes. A walk starts when a request carrying a virtual address and an access kind (read, write or execute) is accepted. The walker then reads one directory entry, which names the page that holds the second-level table, and one table entry, which names the data page and its rights.

A walk ends in one of three ways: a translation carrying the physical address and the page's right bits, a not-present fault, or a protection fault. When a write is permitted and the table entry is still clean, the walker writes the entry back with its dirty bit set before it reports the translation. Memory is reached through a single request/acknowledge port, one access outstanding at a time, and only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `mem_req` and `rsp_valid` are all 0.
- R2: A request is accepted on a clock edge where `req_valid` is 1 and `busy` is 0. The walker then raises `busy`, and in the next cycle it issues a memory read (`mem_we`=0) at the root register value plus 4 times virtual address bits 31:22.
- R3: After the directory entry is acknowledged and found live, the next memory access is a read at the directory entry's bits 31:12 followed by twelve zero bits, plus 4 times virtual address bits 21:12.
- R4: A successful walk reports `rsp_fault`=0, with `rsp_paddr` made of table entry bits 31:12 followed by virtual address bits 11:0. `rsp_flags` reports bit0=read, bit1=write, bit2=execute and bit3=dirty as the entry holds them after any update.
- R5: An entry is live only when its bit0 (valid) and its bit1 (resident) are both 1. If either entry read is not live, the walk ends with `rsp_fault`=1, `rsp_paddr`=0 and `rsp_flags`=0, and no further memory access is made.
- R6: Table entry bit2 grants read, bit3 grants write and bit4 grants execute. Access kind 0 is read, 1 is write, 2 is execute, and 3 is never granted. A live entry that does not grant the access kind ends the walk with `rsp_fault`=2, `rsp_paddr`=0 and `rsp_flags`=0.
- R7: A granted write whose table entry has bit5 (dirty) clear issues a memory write to the table entry's address, with the entry's data plus bit5 set. The response follows the acknowledge of that write. If bit5 is already set, no write is made.
- R8: While `busy` is 1, `req_valid` is ignored. `busy` falls in the cycle that `rsp_valid` is 1, and a request held in that cycle is accepted at the next edge.
- R9: `root_wr` loads `root_val` into the root register. A walk uses the value the register held before the edge that accepts it, so a load in the accepting cycle applies only to later walks.
- R10: `rsp_valid` and `mem_req` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_wr | input | 1 | Load strobe for the root register |
| root_val | input | 32 | New root physical address |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| busy | output | 1 | A walk is in flight |
| mem_req | output | 1 | Memory access strobe, one cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry data for a write |
| mem_ack | input | 1 | Memory acknowledge; read data valid |
| mem_rdata | input | 32 | Entry read data |
| rsp_valid | output | 1 | Walk result strobe, one cycle |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_flags | output | 4 | Page rights and dirty state |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 protection |

## Verification
Two events can fall in the same cycle. A root reload can coincide with the acceptance of a walk, and a new request can coincide with the response of the walk before it. The bench drives a root load together with a request and judges, through the returned physical address, that the walk used the old root and the following walk the new one. It also holds `req_valid` high across a response so that acceptance lands in the response cycle, and a behavioural model compares every memory access and every response on each clock.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_t;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PROT   = 2'd2
  } fault_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIR_WAIT,
    ST_TBL_WAIT,
    ST_WB_WAIT
  } walk_state_t;

  // entry bit positions
  localparam int unsigned BIT_VALID   = 0;
  localparam int unsigned BIT_PRESENT = 1;
  localparam int unsigned BIT_READ    = 2;
  localparam int unsigned BIT_WRITE   = 3;
  localparam int unsigned BIT_EXEC    = 4;
  localparam int unsigned BIT_DIRTY   = 5;

  localparam int unsigned FLAG_W = 4;

endpackage

// File: rtl/walk_root_reg.sv
module walk_root_reg #(
  parameter int unsigned       PA_W     = 32,
  parameter logic [PA_W-1:0]   ROOT_RST = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [PA_W-1:0] wr_val,
  output logic [PA_W-1:0] root
);

  always_ff @(posedge clk) begin
    if (rst) begin
      root <= ROOT_RST;
    end else if (wr_en) begin
      root <= wr_val;
    end
  end

endmodule

// File: rtl/walk_addr_gen.sv
module walk_addr_gen #(
  parameter int unsigned PA_W        = 32,
  parameter int unsigned PAGE_BITS   = 12,
  parameter int unsigned IDX_W       = 10,
  parameter int unsigned ENTRY_BYTES = 4
) (
  input  logic [PA_W-1:0]           root,
  input  logic [IDX_W-1:0]          dir_idx,
  input  logic [PA_W-PAGE_BITS-1:0] dir_ppn,
  input  logic [IDX_W-1:0]          tbl_idx,
  output logic [PA_W-1:0]           dir_addr,
  output logic [PA_W-1:0]           tbl_addr
);

  localparam int unsigned SCALE = $clog2(ENTRY_BYTES);

  logic [PA_W-1:0] tbl_base;

  always_comb begin
    tbl_base = {dir_ppn, {PAGE_BITS{1'b0}}};
    dir_addr = root + (PA_W'(dir_idx) << SCALE);
    tbl_addr = tbl_base + (PA_W'(tbl_idx) << SCALE);
  end

endmodule

// File: rtl/walk_entry_check.sv
module walk_entry_check
  import walk_pkg::*;
#(
  parameter int unsigned ENTRY_W = 32,
  parameter int unsigned PPN_W   = 20
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [1:0]         kind,
  output logic [PPN_W-1:0]   ppn,
  output logic               live,
  output logic               perm_ok,
  output logic               dirty_needed,
  output logic [FLAG_W-1:0]  flags,
  output logic [ENTRY_W-1:0] marked
);

  always_comb begin
    ppn  = entry[ENTRY_W-1 -: PPN_W];
    live = entry[BIT_VALID] & entry[BIT_PRESENT];
    unique case (acc_kind_t'(kind))
      ACC_READ:  perm_ok = entry[BIT_READ];
      ACC_WRITE: perm_ok = entry[BIT_WRITE];
      ACC_EXEC:  perm_ok = entry[BIT_EXEC];
      default:   perm_ok = 1'b0;
    endcase
    dirty_needed = (acc_kind_t'(kind) == ACC_WRITE) & ~entry[BIT_DIRTY];
    marked       = entry | (ENTRY_W'(1) << BIT_DIRTY);
    flags        = {entry[BIT_DIRTY] | dirty_needed,
                    entry[BIT_EXEC], entry[BIT_WRITE], entry[BIT_READ]};
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import walk_pkg::*;
#(
  parameter int unsigned     VA_W        = 32,
  parameter int unsigned     PA_W        = 32,
  parameter int unsigned     PAGE_BITS   = 12,
  parameter int unsigned     IDX_W       = 10,
  parameter int unsigned     ENTRY_BYTES = 4,
  parameter logic [PA_W-1:0] ROOT_RST    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              root_wr,
  input  logic [PA_W-1:0]   root_val,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [PA_W-1:0]   mem_wdata,
  input  logic              mem_ack,
  input  logic [PA_W-1:0]   mem_rdata,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [FLAG_W-1:0] rsp_flags,
  output logic [1:0]        rsp_fault
);

  localparam int unsigned PPN_W = PA_W - PAGE_BITS;
  localparam int unsigned LOW_W = VA_W - IDX_W;
  localparam int unsigned ENTRY_W = ENTRY_BYTES * 8;

  walk_state_t           state_q;
  logic [LOW_W-1:0]      vaddr_q;
  logic [1:0]            kind_q;
  logic [PA_W-1:0]       root;
  logic [PA_W-1:0]       dir_addr;
  logic [PA_W-1:0]       tbl_addr;
  logic [PPN_W-1:0]      ent_ppn;
  logic                  ent_live;
  logic                  ent_perm;
  logic                  ent_dirty_needed;
  logic [FLAG_W-1:0]     ent_flags;
  logic [ENTRY_W-1:0]    ent_marked;

  walk_root_reg #(
    .PA_W     (PA_W),
    .ROOT_RST (ROOT_RST)
  ) u_root (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (root_wr),
    .wr_val (root_val),
    .root   (root)
  );

  walk_addr_gen #(
    .PA_W        (PA_W),
    .PAGE_BITS   (PAGE_BITS),
    .IDX_W       (IDX_W),
    .ENTRY_BYTES (ENTRY_BYTES)
  ) u_addr (
    .root     (root),
    .dir_idx  (req_vaddr[VA_W-1 -: IDX_W]),
    .dir_ppn  (ent_ppn),
    .tbl_idx  (vaddr_q[PAGE_BITS +: IDX_W]),
    .dir_addr (dir_addr),
    .tbl_addr (tbl_addr)
  );

  walk_entry_check #(
    .ENTRY_W (ENTRY_W),
    .PPN_W   (PPN_W)
  ) u_check (
    .entry        (mem_rdata),
    .kind         (kind_q),
    .ppn          (ent_ppn),
    .live         (ent_live),
    .perm_ok      (ent_perm),
    .dirty_needed (ent_dirty_needed),
    .flags        (ent_flags),
    .marked       (ent_marked)
  );

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      vaddr_q   <= '0;
      kind_q    <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_flags <= '0;
      rsp_fault <= FLT_NONE;
    end else begin
      mem_req   <= 1'b0;
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q  <= req_vaddr[LOW_W-1:0];
            kind_q   <= req_kind;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= dir_addr;
            state_q  <= ST_DIR_WAIT;
          end
        end
        ST_DIR_WAIT: begin
          if (mem_ack) begin
            if (!ent_live) begin
              rsp_valid <= 1'b1;
              rsp_fault <= FLT_ABSENT;
              rsp_paddr <= '0;
              rsp_flags <= '0;
              state_q   <= ST_IDLE;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= tbl_addr;
              state_q  <= ST_TBL_WAIT;
            end
          end
        end
        ST_TBL_WAIT: begin
          if (mem_ack) begin
            if (!ent_live || !ent_perm) begin
              rsp_valid <= 1'b1;
              rsp_fault <= ent_live ? FLT_PROT : FLT_ABSENT;
              rsp_paddr <= '0;
              rsp_flags <= '0;
              state_q   <= ST_IDLE;
            end else begin
              rsp_paddr <= {ent_ppn, vaddr_q[PAGE_BITS-1:0]};
              rsp_flags <= ent_flags;
              rsp_fault <= FLT_NONE;
              if (ent_dirty_needed) begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_wdata <= ent_marked;
                state_q   <= ST_WB_WAIT;
              end else begin
                rsp_valid <= 1'b1;
                state_q   <= ST_IDLE;
              end
            end
          end
        end
        ST_WB_WAIT: begin
          if (mem_ack) begin
            mem_we    <= 1'b0;
            rsp_valid <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker_sva.sv
module pt_walker_sva #(
  parameter int unsigned LOW_W = 22
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             mem_req,
  input logic             mem_we,
  input logic [31:0]      mem_wdata,
  input logic             rsp_valid,
  input logic [31:0]      rsp_paddr,
  input logic [3:0]       rsp_flags,
  input logic [1:0]       rsp_fault,
  input logic [1:0]       kind_q,
  input logic [LOW_W-1:0] vaddr_q
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !mem_req && !rsp_valid)); // R1

  AST_FIRST_ACCESS_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mem_req && !mem_we)); // R2

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[11:0] == vaddr_q[11:0])); // R4

  AST_FAULT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == 32'd0 && rsp_flags == 4'd0)); // R5

  AST_WB_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata[5] && kind_q == 2'd1)); // R7

  AST_SUCCESS_WRITE_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 2'd0 && kind_q == 2'd1) |-> rsp_flags[3]); // R7

  AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy); // R8

  AST_RSP_ENDS_WALK: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!busy && $past(busy))); // R8

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R10

  AST_MEMREQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R10

endmodule

bind pt_walker pt_walker_sva #(.LOW_W(LOW_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_flags (rsp_flags),
  .rsp_fault (rsp_fault),
  .kind_q    (kind_q),
  .vaddr_q   (vaddr_q)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        root_wr = 1'b0;
  logic [31:0] root_val = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        busy;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [3:0]  rsp_flags;
  logic [1:0]  rsp_fault;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk, .rst, .root_wr, .root_val, .req_valid, .req_vaddr, .req_kind,
    .busy, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .rsp_valid, .rsp_paddr, .rsp_flags, .rsp_fault
  );

  typedef struct {
    logic [31:0] a;
    logic        we;
    logic [31:0] d;
    string       tag;
  } acc_t;

  typedef struct {
    logic [31:0] pa;
    logic [3:0]  fl;
    logic [1:0]  ft;
    string       tag;
  } rsp_t;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int lat = 0;
  bit [31:0] mem [bit [31:0]];
  acc_t exp_acc[$];
  rsp_t exp_rsp[$];
  bit [31:0] root_m = 32'h0;
  bit open_m = 1'b0;
  bit prev_rsp = 1'b0;
  bit prev_req = 1'b0;
  logic [31:0] last_pa;
  logic [1:0]  last_ft;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit [31:0] rd(input bit [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // behavioural expectation of one walk
  function automatic void predict(input bit [31:0] root, input bit [31:0] va,
                                  input bit [1:0] kind);
    bit [31:0] da, ta, de, te;
    bit ok;
    da = root + 32'(va[31:22]) * 4;
    exp_acc.push_back('{da, 1'b0, 32'h0, "R2"});
    de = rd(da);
    if (!(de[0] && de[1])) begin
      exp_rsp.push_back('{32'h0, 4'h0, 2'd1, "R5"});
      return;
    end
    ta = {de[31:12], 12'h000} + 32'(va[21:12]) * 4;
    exp_acc.push_back('{ta, 1'b0, 32'h0, "R3"});
    te = rd(ta);
    if (!(te[0] && te[1])) begin
      exp_rsp.push_back('{32'h0, 4'h0, 2'd1, "R5"});
      return;
    end
    case (kind)
      2'd0: ok = te[2];
      2'd1: ok = te[3];
      2'd2: ok = te[4];
      default: ok = 1'b0;
    endcase
    if (!ok) begin
      exp_rsp.push_back('{32'h0, 4'h0, 2'd2, "R6"});
      return;
    end
    if (kind == 2'd1 && !te[5]) begin
      te = te | 32'h20;
      exp_acc.push_back('{ta, 1'b1, te, "R7"});
    end
    exp_rsp.push_back('{{te[31:12], va[11:0]}, {te[5], te[4], te[3], te[2]}, 2'd0, "R4"});
  endfunction

  // memory model: acknowledges lat cycles after the strobe
  bit          m_pend = 1'b0;
  int          m_cnt = 0;
  bit [31:0]   m_addr;
  bit          m_we;
  bit [31:0]   m_wdata;
  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (m_pend) begin
      if (m_cnt == 0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= rd(m_addr);
        if (m_we) mem[m_addr] = m_wdata;
        m_pend = 1'b0;
      end else begin
        m_cnt--;
      end
    end
    if (mem_req && !rst) begin
      m_pend  = 1'b1;
      m_cnt   = lat;
      m_addr  = mem_addr;
      m_we    = mem_we;
      m_wdata = mem_wdata;
    end
  end

  // reference comparison on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        chk(!prev_rsp, "R10", "rsp_valid pulse", 32'(rsp_valid), 32'd0);
        if (exp_rsp.size() == 0) begin
          chk(1'b0, "R4", "unexpected response", rsp_paddr, 32'h0);
        end else begin
          rsp_t e;
          e = exp_rsp.pop_front();
          chk(rsp_fault == e.ft, e.tag, "fault", 32'(rsp_fault), 32'(e.ft));
          chk(rsp_paddr == e.pa, e.tag, "paddr", rsp_paddr, e.pa);
          chk(rsp_flags == e.fl, e.tag, "flags", 32'(rsp_flags), 32'(e.fl));
        end
        open_m = 1'b0;
      end
      chk(busy == open_m, "R8", "busy", 32'(busy), 32'(open_m));
      if (mem_req) begin
        chk(!prev_req, "R10", "mem_req pulse", 32'(mem_req), 32'd0);
        if (exp_acc.size() == 0) begin
          chk(1'b0, "R5", "unexpected memory access", mem_addr, 32'h0);
        end else begin
          acc_t e;
          e = exp_acc.pop_front();
          chk(mem_addr == e.a, e.tag, "mem_addr", mem_addr, e.a);
          chk(mem_we == e.we, e.tag, "mem_we", 32'(mem_we), 32'(e.we));
          if (e.we) chk(mem_wdata == e.d, e.tag, "mem_wdata", mem_wdata, e.d);
        end
      end
      prev_rsp = rsp_valid;
      prev_req = mem_req;
      if (req_valid && !open_m) begin
        predict(root_m, req_vaddr, req_kind);
        open_m = 1'b1;
      end
      if (root_wr) root_m = root_val;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic set_root(input logic [31:0] v);
    @(posedge clk); #2;
    root_wr = 1'b1; root_val = v;
    @(posedge clk); #2;
    root_wr = 1'b0;
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] kind);
    @(posedge clk); #2;
    req_valid = 1'b1; req_vaddr = va; req_kind = kind;
    do @(negedge clk); while (busy);
    @(posedge clk); #2;
    req_valid = 1'b0;
    do @(negedge clk); while (!rsp_valid);
    last_pa = rsp_paddr;
    last_ft = rsp_fault;
  endtask

  // place a directory entry and a table entry for va under root
  task automatic map(input bit [31:0] root, input bit [31:0] va,
                     input bit [31:0] de, input bit [31:0] te);
    mem[root + 32'(va[31:22]) * 4] = de;
    mem[{de[31:12], 12'h000} + 32'(va[21:12]) * 4] = te;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 32'd0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'd0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);

    // R3/R4: read of a readable page; entry: ppn 14817, valid, resident, R W
    set_root(32'h1000_5000);
    map(32'h1000_5000, 32'h7192_a44c, 32'h1234_5003, 32'h1481_700f);
    walk(32'h7192_a44c, 2'd0);
    chk(last_pa == 32'h1481_744c, "R4", "read translation", last_pa, 32'h1481_744c);

    // R6: execute not granted
    lat = 2;
    walk(32'h7192_a000, 2'd2);
    chk(last_ft == 2'd2, "R6", "exec protection fault", 32'(last_ft), 32'd2);
    walk(32'h7192_a000, 2'd3);
    chk(last_ft == 2'd2, "R6", "reserved kind fault", 32'(last_ft), 32'd2);

    // R7: first write sets dirty, second write makes no write
    lat = 1;
    walk(32'h7192_a123, 2'd1);
    chk(mem[32'h1234_5000 + 32'h12a * 4] == 32'h1481_702f, "R7", "entry marked dirty",
        mem[32'h1234_5000 + 32'h12a * 4], 32'h1481_702f);
    walk(32'h7192_a124, 2'd1);

    // R5: directory entry not valid, table entry valid but not resident
    lat = 0;
    mem[32'h1000_5000 + 32'h010 * 4] = 32'h2222_2002;
    walk(32'h0400_0000, 2'd0);
    chk(last_ft == 2'd1, "R5", "invalid directory entry", 32'(last_ft), 32'd1);
    map(32'h1000_5000, 32'h0800_3000, 32'h3333_3003, 32'h4444_401d);
    walk(32'h0800_3000, 2'd0);
    chk(last_ft == 2'd1, "R5", "non-resident table entry", 32'(last_ft), 32'd1);

    // R6: write to a read-only page
    map(32'h1000_5000, 32'h0c00_1000, 32'h3333_4003, 32'h5555_5007);
    walk(32'h0c00_1abc, 2'd1);
    chk(last_ft == 2'd2, "R6", "write to read-only page", 32'(last_ft), 32'd2);

    // R9: root reload in the accepting cycle applies to the next walk only
    map(32'h2000_0000, 32'h7192_a44c, 32'h3333_5003, 32'h6666_6017);
    @(posedge clk); #2;
    req_valid = 1'b1; req_vaddr = 32'h7192_a44c; req_kind = 2'd0;
    root_wr = 1'b1; root_val = 32'h2000_0000;
    @(posedge clk); #2;
    req_valid = 1'b0; root_wr = 1'b0;
    do @(negedge clk); while (!rsp_valid);
    chk(rsp_paddr == 32'h1481_744c, "R9", "old root used", rsp_paddr, 32'h1481_744c);
    walk(32'h7192_a44c, 2'd0);
    chk(last_pa == 32'h6666_644c, "R9", "new root used", last_pa, 32'h6666_644c);

    // R8: requests held while busy, back-to-back acceptance in response cycle
    lat = 3;
    @(posedge clk); #2;
    req_valid = 1'b1; req_vaddr = 32'h7192_a010; req_kind = 2'd2;
    @(posedge clk); #2;
    req_vaddr = 32'h0400_0000; req_kind = 2'd0;
    @(negedge clk);
    chk(busy == 1'b1, "R8", "busy during walk", 32'(busy), 32'd1);
    do @(negedge clk); while (!rsp_valid);
    chk(rsp_paddr == 32'h6666_6010, "R8", "held request ignored", rsp_paddr, 32'h6666_6010);
    @(posedge clk); #2;
    req_valid = 1'b0;
    do @(negedge clk); while (!rsp_valid);
    chk(rsp_fault == 2'd1, "R8", "queued request served", 32'(rsp_fault), 32'd1);

    repeat (6) @(negedge clk);
    chk(exp_acc.size() == 0, "R3", "accesses outstanding", 32'(exp_acc.size()), 32'd0);
    chk(exp_rsp.size() == 0, "R4", "responses outstanding", 32'(exp_rsp.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule